// File: doc/BRIEF.md
# Per-Bank Row Timing and Auto-Precharge Tracker

This block sits beside a memory controller's command sequencer and keeps, for every bank of a DRAM device, the cycle counters that decide when that bank may next be opened, accessed or closed. The sequencer presents each decoded command with its bank number, its auto-precharge flag and the burst length in force. The block answers with per-bank "may issue" flags for activate, column access (read or write) and precharge, plus a single-cycle pulse whenever it starts an internal precharge on behalf of an auto-precharge access.

All delays are module parameters in whole clock cycles: activate-to-column delay, minimum row-open time, write recovery and precharge time. A command that arrives while its flag is low is dropped without touching any bank state. The sequencer is expected to look at the flags before issuing. An all-banks-idle flag tells the refresh logic when a refresh may go out.

Top module: `bank_timer_unit`

## Requirements
- R1: After reset every bank is closed with its precharge time already served: all activate flags are 1, all column, precharge and auto-precharge outputs are 0, and the refresh-allowed flag is 1.
- R2: Command codes on `cmd_op` are 0 idle, 1 activate, 2 read, 3 write, 4 precharge. After an activate accepted at edge k, the column flag of that bank is 0 until edge k+T_RCD and 1 from then on while the row is open and no auto-precharge is pending.
- R3: The precharge flag of an open bank is 1 only once T_RAS cycles have passed since its activate and, after a write, once the write burst (burst length / 2 cycles) plus T_WR cycles have passed since the write command.
- R4: A read with auto-precharge accepted at edge k raises that bank's auto-precharge pulse after edge k+BL/2 when the row-open minimum has already been served by then.
- R5: When the row-open minimum is not yet served at that point, the auto-precharge pulse is deferred until the cycle in which T_RAS has elapsed since the activate.
- R6: A write with auto-precharge accepted at edge k raises the pulse after edge k+BL/2+T_WR.
- R7: The auto-precharge pulse lasts exactly one cycle. On the following edge the bank closes, its activate flag stays 0 for T_RP cycles, then returns to 1; an explicit precharge likewise closes the bank for T_RP cycles.
- R8: A command whose flag for the addressed bank is 0 (early precharge, read to a closed bank, any column command while an auto-precharge is pending) is ignored and changes no output.
- R9: The refresh-allowed flag is 1 exactly when every bank is closed and has served its precharge time.
- R10: `bl_code` selects the burst length per command: 0 gives 2, 1 gives 4, 2 and 3 give 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_op | input | 3 | Command code (see R2) |
| cmd_bank | input | BANK_W (2) | Addressed bank |
| cmd_ap | input | 1 | Auto-precharge flag for read or write |
| bl_code | input | 2 | Burst length selector (see R10) |
| act_ok | output | NUM_BANKS (4) | Per-bank activate allowed |
| col_ok | output | NUM_BANKS (4) | Per-bank read/write allowed |
| pre_ok | output | NUM_BANKS (4) | Per-bank explicit precharge allowed |
| ap_start | output | NUM_BANKS (4) | Per-bank one-cycle internal precharge start |
| ref_ok | output | 1 | All banks idle and precharged |

## Verification
The main stimulus is a two-bank interleave: one bank takes a short-burst read with auto-precharge soon after opening, so the row-open minimum rather than the burst decides the pulse, while the other takes a plain write followed by an early and a timely precharge, which separates write recovery from row-open timing. A late read with auto-precharge at the longest burst shows the burst-bound case, and a write with auto-precharge using the reserved burst code shows the write-recovery-bound case and the reserved code decode. Dropped commands (early precharge, read to a closed bank) are checked by the flags staying where timing alone puts them.

// File: rtl/bt_pkg.sv
package bt_pkg;

   typedef enum logic [2:0] {
      OP_IDLE = 3'd0,
      OP_ACT  = 3'd1,
      OP_RD   = 3'd2,
      OP_WR   = 3'd3,
      OP_PRE  = 3'd4
   } bt_op_e;

   // burst length / 2 for a given selector code
   function automatic logic [3:0] half_burst(input logic [1:0] code);
      case (code)
         2'd0:    half_burst = 4'd1;
         2'd1:    half_burst = 4'd2;
         default: half_burst = 4'd4;
      endcase
   endfunction

endpackage

// File: rtl/bt_downcnt.sv
module bt_downcnt #(
   parameter int W = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ld,
   input  logic [W-1:0] ld_val,
   output logic         zero
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (ld)             cnt_q <= ld_val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);

endmodule

// File: rtl/bt_bank_slot.sv
module bt_bank_slot
   import bt_pkg::*;
#(
   parameter int CNT_W = 6,
   parameter int T_RCD = 3,
   parameter int T_RAS = 6,
   parameter int T_WR  = 2,
   parameter int T_RP  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel,
   input  bt_op_e           op,
   input  logic             ap,
   input  logic [CNT_W-1:0] half_bl,
   output logic             act_ok,
   output logic             col_ok,
   output logic             pre_ok,
   output logic             ap_start
);
   logic open_q, pend_q;
   logic rcd_z, ras_z, wr_z, bst_z, rp_z;
   logic act_acc, rd_acc, wr_acc, pre_acc, col_acc, fire;

   assign act_ok   = !open_q && rp_z;
   assign col_ok   = open_q && rcd_z && !pend_q;
   assign pre_ok   = open_q && ras_z && wr_z && !pend_q;

   assign act_acc  = sel && (op == OP_ACT) && act_ok;
   assign rd_acc   = sel && (op == OP_RD)  && col_ok;
   assign wr_acc   = sel && (op == OP_WR)  && col_ok;
   assign pre_acc  = sel && (op == OP_PRE) && pre_ok;
   assign col_acc  = rd_acc || wr_acc;
   assign fire     = pend_q && bst_z && ras_z && wr_z;
   assign ap_start = fire;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         if (act_acc)               open_q <= 1'b1;
         else if (pre_acc || fire)  open_q <= 1'b0;
         if (col_acc && ap)         pend_q <= 1'b1;
         else if (fire)             pend_q <= 1'b0;
      end
   end

   bt_downcnt #(.W(CNT_W)) u_rcd (
      .clk(clk), .rst_n(rst_n), .ld(act_acc),
      .ld_val(CNT_W'(T_RCD)), .zero(rcd_z));

   bt_downcnt #(.W(CNT_W)) u_ras (
      .clk(clk), .rst_n(rst_n), .ld(act_acc),
      .ld_val(CNT_W'(T_RAS)), .zero(ras_z));

   bt_downcnt #(.W(CNT_W)) u_wr (
      .clk(clk), .rst_n(rst_n), .ld(wr_acc),
      .ld_val(half_bl + CNT_W'(T_WR)), .zero(wr_z));

   bt_downcnt #(.W(CNT_W)) u_bst (
      .clk(clk), .rst_n(rst_n), .ld(col_acc && ap),
      .ld_val(half_bl), .zero(bst_z));

   bt_downcnt #(.W(CNT_W)) u_rp (
      .clk(clk), .rst_n(rst_n), .ld(pre_acc || fire),
      .ld_val(CNT_W'(T_RP)), .zero(rp_z));

   // R2: a fresh activate never allows a column command on the next cycle
   p_col_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
      act_acc |=> !col_ok);

   // R3: an accepted write blocks precharge on the next cycle
   p_wr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_acc |=> !pre_ok);

   // R5: no internal precharge right after the row was opened
   p_act_no_ap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      act_acc |=> !ap_start);

   // R7: one-cycle pulse, bank then unavailable for activate
   p_ap_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ap_start |=> (!ap_start && !act_ok));

   // R7: explicit precharge closes the bank
   p_pre_close_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pre_acc |=> (!col_ok && !act_ok));

endmodule

// File: rtl/bank_timer_unit.sv
module bank_timer_unit
   import bt_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int CNT_W     = 6,
   parameter int T_RCD     = 3,
   parameter int T_RAS     = 6,
   parameter int T_WR      = 2,
   parameter int T_RP      = 3,
   localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
   localparam int CNT_MAX  = (1 << CNT_W) - 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cmd_valid,
   input  logic [2:0]           cmd_op,
   input  logic [BANK_W-1:0]    cmd_bank,
   input  logic                 cmd_ap,
   input  logic [1:0]           bl_code,
   output logic [NUM_BANKS-1:0] act_ok,
   output logic [NUM_BANKS-1:0] col_ok,
   output logic [NUM_BANKS-1:0] pre_ok,
   output logic [NUM_BANKS-1:0] ap_start,
   output logic                 ref_ok
);
   if (NUM_BANKS < 1) begin : g_chk_banks
      $error("NUM_BANKS must be at least 1");
   end
   if (T_RCD < 1 || T_RAS < 1 || T_RP < 1) begin : g_chk_min
      $error("T_RCD, T_RAS and T_RP must be at least one cycle");
   end
   if (T_WR < 0 || T_RCD > CNT_MAX || T_RAS > CNT_MAX || T_RP > CNT_MAX
       || (T_WR + 4) > CNT_MAX) begin : g_chk_width
      $error("timing parameter does not fit CNT_W");
   end

   bt_op_e           op;
   logic [CNT_W-1:0] half_bl;

   assign op      = bt_op_e'(cmd_op);
   assign half_bl = CNT_W'(half_burst(bl_code));

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic sel;
      assign sel = cmd_valid && (cmd_bank == BANK_W'(b));

      bt_bank_slot #(
         .CNT_W(CNT_W), .T_RCD(T_RCD), .T_RAS(T_RAS),
         .T_WR(T_WR), .T_RP(T_RP)
      ) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .sel      (sel),
         .op       (op),
         .ap       (cmd_ap),
         .half_bl  (half_bl),
         .act_ok   (act_ok[b]),
         .col_ok   (col_ok[b]),
         .pre_ok   (pre_ok[b]),
         .ap_start (ap_start[b])
      );
   end

   assign ref_ok = &act_ok;

   // R9: refresh permission excludes any pending internal precharge
   p_ref_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ref_ok |-> (ap_start == '0 && col_ok == '0));

   // R8: a bank is never both activatable and column-accessible
   p_flags_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (act_ok & (col_ok | pre_ok)) == '0);

endmodule

// File: tb/bank_timer_unit_tb_top.sv
`timescale 1ns/1ps
module bank_timer_unit_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0;
   logic [2:0] cmd_op = 3'd0;
   logic [1:0] cmd_bank = 2'd0;
   logic       cmd_ap = 1'b0;
   logic [1:0] bl_code = 2'd0;
   logic [3:0] act_ok, col_ok, pre_ok, ap_start;
   logic       ref_ok;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always #2 clk = ~clk;   // 250 MHz

   bank_timer_unit dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_bank(cmd_bank), .cmd_ap(cmd_ap), .bl_code(bl_code),
      .act_ok(act_ok), .col_ok(col_ok), .pre_ok(pre_ok),
      .ap_start(ap_start), .ref_ok(ref_ok));

   // row: op[24:22] bank[21:20] ap[19] bl[18:17] act[16:13] col[12:9] pre[8:5] aps[4:1] ref[0]
   localparam logic [24:0] VEC [15] = '{
      {3'd1, 2'd0, 1'b0, 2'd1, 4'hE, 4'h0, 4'h0, 4'h0, 1'b0},  // R2 open bank 0
      {3'd1, 2'd1, 1'b0, 2'd1, 4'hC, 4'h0, 4'h0, 4'h0, 1'b0},  // open bank 1
      {3'd0, 2'd0, 1'b0, 2'd1, 4'hC, 4'h0, 4'h0, 4'h0, 1'b0},
      {3'd0, 2'd0, 1'b0, 2'd1, 4'hC, 4'h1, 4'h0, 4'h0, 1'b0},  // R2 bank 0 column ready
      {3'd2, 2'd0, 1'b1, 2'd0, 4'hC, 4'h2, 4'h0, 4'h0, 1'b0},  // R5 R10 read+ap, BL2
      {3'd3, 2'd1, 1'b0, 2'd1, 4'hC, 4'h2, 4'h0, 4'h0, 1'b0},  // R3 write bank 1
      {3'd0, 2'd0, 1'b0, 2'd1, 4'hC, 4'h2, 4'h0, 4'h1, 1'b0},  // R5 deferred pulse
      {3'd0, 2'd0, 1'b0, 2'd1, 4'hC, 4'h2, 4'h0, 4'h0, 1'b0},  // R7 pulse gone
      {3'd4, 2'd1, 1'b0, 2'd1, 4'hC, 4'h2, 4'h0, 4'h0, 1'b0},  // R8 early precharge dropped
      {3'd0, 2'd0, 1'b0, 2'd1, 4'hC, 4'h2, 4'h2, 4'h0, 1'b0},  // R3 recovery served
      {3'd2, 2'd0, 1'b0, 2'd1, 4'hD, 4'h2, 4'h2, 4'h0, 1'b0},  // R8 read to closed bank, R7 tRP done
      {3'd4, 2'd1, 1'b0, 2'd1, 4'hD, 4'h0, 4'h0, 4'h0, 1'b0},  // R7 explicit precharge
      {3'd0, 2'd0, 1'b0, 2'd1, 4'hD, 4'h0, 4'h0, 4'h0, 1'b0},
      {3'd0, 2'd0, 1'b0, 2'd1, 4'hD, 4'h0, 4'h0, 4'h0, 1'b0},
      {3'd0, 2'd0, 1'b0, 2'd1, 4'hF, 4'h0, 4'h0, 4'h0, 1'b1}   // R9 all idle
   };

   task automatic issue(input logic [2:0] op, input logic [1:0] bank,
                        input logic ap, input logic [1:0] bl);
      @(negedge clk);
      cmd_valid = (op != 3'd0);
      cmd_op    = op;
      cmd_bank  = bank;
      cmd_ap    = ap;
      bl_code   = bl;
      @(posedge clk);
      #1;
      cmd_valid = 1'b0;
      cmd_op    = 3'd0;
      cmd_ap    = 1'b0;
   endtask

   task automatic idle_cycles(input int n);
      for (int i = 0; i < n; i++) issue(3'd0, 2'd0, 1'b0, 2'd1);
   endtask

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 4);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 reset flags", {15'd0, act_ok, col_ok, pre_ok, ap_start, ref_ok},
            {15'd0, 4'hF, 4'h0, 4'h0, 4'h0, 1'b1});

      // table walk: two banks interleaved
      for (int i = 0; i < 15; i++) begin
         issue(VEC[i][24:22], VEC[i][21:20], VEC[i][19], VEC[i][18:17]);
         check($sformatf("table row %0d (R2 R3 R5 R7 R8 R9 R10)", i),
               {15'd0, act_ok, col_ok, pre_ok, ap_start, ref_ok},
               {15'd0, VEC[i][16:0]});
      end

      // R4: read+ap with row minimum already served, BL8 (code 2)
      issue(3'd1, 2'd2, 1'b0, 2'd1);
      idle_cycles(6);
      issue(3'd2, 2'd2, 1'b1, 2'd2);
      check("R8 column blocked while ap pending", {28'd0, col_ok}, 32'h0);
      idle_cycles(3);
      check("R4 no pulse before BL/2", {28'd0, ap_start}, 32'h0);
      idle_cycles(1);
      check("R4 pulse at BL/2", {28'd0, ap_start}, 32'h4);

      // R6 R10: write+ap, reserved code 3 acts as BL8
      issue(3'd1, 2'd3, 1'b0, 2'd1);
      idle_cycles(3);
      issue(3'd3, 2'd3, 1'b1, 2'd3);
      idle_cycles(5);
      check("R6 R10 no pulse before recovery", {28'd0, ap_start}, 32'h0);
      idle_cycles(1);
      check("R6 R10 pulse after burst plus recovery", {28'd0, ap_start}, 32'h8);
      idle_cycles(1);
      check("R7 pulse one cycle", {28'd0, ap_start}, 32'h0);
      check("R7 bank closed, activate blocked", {31'd0, act_ok[3]}, 32'h0);
      idle_cycles(2);
      check("R7 activate still blocked in tRP", {31'd0, act_ok[3]}, 32'h0);
      idle_cycles(1);
      check("R7 activate after tRP", {31'd0, act_ok[3]}, 32'h1);
      check("R9 refresh allowed again", {31'd0, ref_ok}, 32'h1);

      finish_run();
   end

endmodule